// File: doc/BRIEF.md
# Tiled Signed 65x65 Multiplier

This block multiplies two 65-bit two's complement integers and returns the exact 130-bit signed product. It is built only from small multiply tiles whose ports are about 25 by 18 bits, the size of a typical hard multiplier slice. Operand A is cut into two 24-bit unsigned slices and one 17-bit signed top slice. The two low A slices each drive a group of four tiles. Within such a group, operand B is split at bits 17, 34 and 51, and the partial products are summed in a cascade that shifts by 17 bits at each step. The short top A slice takes the narrow tile port instead. Its group therefore needs only three tiles, with B cut into 24-bit pieces. The three group results are weighted by 1, 2^24 and 2^48 and summed by two single-cycle adders.

The parameter `SHARED` selects one of two variants. When it is 0, the block uses eleven tiles and accepts a new operand pair on every cycle. When it is 1, the block uses seven tiles: the two low A slices take turns on one four-tile group. A small sequencer then steers the group's input multiplexer, and the top group is fed one cycle later. In both variants a valid bit travels with the data, and each product appears exactly seven cycles after its operands are taken.

Top module: `tmul65`

## Requirements
- R1: The operands `in_a` and `in_b` are 65-bit two's complement values, with bit 64 as the sign. `out_p` is their exact 130-bit two's complement product.
- R2: A pair taken on the rising edge where `in_valid` and `in_ready` are both high produces `out_valid` high, with its product on `out_p`, exactly seven rising edges later.
- R3: With `SHARED`=0, `in_ready` is always high. A new pair is taken on every cycle, and the results leave in the order the pairs were taken.
- R4: With `SHARED`=1, `in_ready` is low for exactly the one cycle after each taken pair and high otherwise. Each taken pair yields exactly one result, in order.
- R5: The product is exact for extreme and boundary operands: zero, ±1, ±(2^64−1), −2^64, and values that sit on the slice edges at bits 17, 24, 34, 48 and 51.
- R6: While and just after `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R7: Cycles with `in_valid` low produce no result: `out_valid` stays low unless an earlier taken pair is due.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | 65 | Multiplicand, two's complement |
| in_b | input | 65 | Multiplier, two's complement |
| out_valid | output | 1 | `out_p` holds a product |
| out_p | output | 130 | Signed product |

## Verification
The bench aims at the sign handling of the top slices. Operands such as −2^64 and ±(2^64−1) break a design that zero-extends the top A or B slice, or that drops the corner tile, and they give wrong high bits. Values that straddle bits 17, 24, 34, 48 and 51 catch a slip of one bit in a shift or slice boundary, which shows up as a product off by a power of two. Continuous bursts test the time-shared variant. There, a sequencer that reopened `in_ready` too early, or that captured the first half-product in the wrong cycle, would pair P0 of one operand with P1 of the next and give mixed-up results. A variant with wrong latency would show results one cycle early or late against the seven-cycle rule.

// File: rtl/tmul_pkg.sv
package tmul_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    parameter int OPW  = 65;          // operand width
    parameter int RESW = 2 * OPW;     // product width
    parameter int ASL  = 24;          // A slice width
    parameter int BSL  = 17;          // B slice width in the wide-A groups
    parameter int TPA  = ASL + 1;     // wide tile port
    parameter int TPB  = BSL + 1;     // narrow tile port
    parameter int NTB  = 4;           // tiles per low group
    parameter int NTC  = 3;           // tiles in the top group
    parameter int LAT  = 7;           // operand to result cycles

    // unsigned low A slice k, zero-extended onto the wide port
    function automatic logic [TPA-1:0] a_low(input logic [OPW-1:0] x, input int k);
        return {1'b0, x[k*ASL +: ASL]};
    endfunction

    // signed top A slice on the narrow port
    function automatic logic [TPB-1:0] a_top(input logic [OPW-1:0] x);
        return TPB'($signed(x[OPW-1:2*ASL]));
    endfunction

    // B cut at 17-bit steps for the narrow port; top piece keeps the sign
    function automatic logic [NTB-1:0][TPB-1:0] b_narrow(input logic [OPW-1:0] x);
        logic [NTB-1:0][TPB-1:0] r;
        for (int k = 0; k < NTB - 1; k++) r[k] = {1'b0, x[k*BSL +: BSL]};
        r[NTB-1] = TPB'($signed(x[OPW-1:(NTB-1)*BSL]));
        return r;
    endfunction

    // B cut at 24-bit steps for the wide port; top piece keeps the sign
    function automatic logic [NTC-1:0][TPA-1:0] b_wide(input logic [OPW-1:0] x);
        logic [NTC-1:0][TPA-1:0] r;
        for (int k = 0; k < NTC - 1; k++) r[k] = {1'b0, x[k*ASL +: ASL]};
        r[NTC-1] = TPA'($signed(x[OPW-1:(NTC-1)*ASL]));
        return r;
    endfunction
endpackage

// File: rtl/tmul_tile_group.sv
module tmul_tile_group #(
    parameter int NT = 4,
    parameter int AW = 25,
    parameter int BW = 18,
    parameter int SH = 17,
    parameter int OW = 130
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [AW-1:0]    a,
    input  logic [NT-1:0][BW-1:0]   b,
    output logic signed [OW-1:0]    p
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PW = AW + BW;

    typedef struct packed {
        logic [NT-1:0][PW-1:0] prod;   // stage 1: tile products
        logic [OW-1:0]         lo;     // stage 2: lower tile pair
        logic [OW-1:0]         hi;     // stage 2: upper tile(s)
        logic [OW-1:0]         p;      // stage 3: group result
    } grp_t;

    grp_t grp_d, grp_q;
    logic signed [OW-1:0] hi_c;

    generate
        if (NT == 4) begin : g_hi4
            assign hi_c = OW'($signed(grp_q.prod[2])) + (OW'($signed(grp_q.prod[3])) <<< SH);
        end else begin : g_hi3
            assign hi_c = OW'($signed(grp_q.prod[2]));
        end
    endgenerate

    always_comb begin
        grp_d = grp_q;
        for (int k = 0; k < NT; k++) begin
            grp_d.prod[k] = PW'(a) * PW'($signed(b[k]));
        end
        grp_d.lo = OW'($signed(grp_q.prod[0])) + (OW'($signed(grp_q.prod[1])) <<< SH);
        grp_d.hi = hi_c;
        grp_d.p  = $signed(grp_q.lo) + ($signed(grp_q.hi) <<< (2 * SH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) grp_q <= '0;
        else        grp_q <= grp_d;
    end

    assign p = $signed(grp_q.p);

    AST_GRP_ZERO_A: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(a, 3) == '0) |-> (p == '0)); // R1
endmodule

// File: rtl/tmul65.sv
module tmul65
    import tmul_pkg::*;
#(
    parameter bit SHARED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OPW-1:0]    in_a,
    input  logic [OPW-1:0]    in_b,
    output logic              out_valid,
    output logic [RESW-1:0]   out_p
);
    timeunit 1ns;
    timeprecision 1ps;

    logic signed [RESW-1:0] p01, p1w, p2;
    logic acc;

    generate
        if (!SHARED) begin : g_pipe
            typedef struct packed {
                logic [OPW-1:0]  a;
                logic [OPW-1:0]  b;
                logic [LAT-1:0]  vs;
                logic [RESW-1:0] r0;
                logic [RESW-1:0] p2d;
                logic [RESW-1:0] fin;
                logic [RESW-1:0] res;
            } pst_t;
            pst_t st_d, st_q;

            assign in_ready = 1'b1;
            assign acc      = in_valid;

            tmul_tile_group #(.NT(NTB), .AW(TPA), .BW(TPB), .SH(BSL), .OW(RESW)) u_grp0 (
                .clk(clk), .rst_n(rst_n), .a(a_low(st_q.a, 0)), .b(b_narrow(st_q.b)), .p(p01));
            tmul_tile_group #(.NT(NTB), .AW(TPA), .BW(TPB), .SH(BSL), .OW(RESW)) u_grp1 (
                .clk(clk), .rst_n(rst_n), .a(a_low(st_q.a, 1)), .b(b_narrow(st_q.b)), .p(p1w));
            tmul_tile_group #(.NT(NTC), .AW(TPB), .BW(TPA), .SH(ASL), .OW(RESW)) u_grp2 (
                .clk(clk), .rst_n(rst_n), .a(a_top(st_q.a)), .b(b_wide(st_q.b)), .p(p2));

            always_comb begin
                st_d     = st_q;
                st_d.a   = in_a;
                st_d.b   = in_b;
                st_d.vs  = {st_q.vs[LAT-2:0], acc};
                st_d.r0  = p01 + (p1w <<< ASL);
                st_d.p2d = p2;
                st_d.fin = $signed(st_q.r0) + ($signed(st_q.p2d) <<< (2 * ASL));
                st_d.res = st_q.fin;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign out_valid = st_q.vs[LAT-1];
            assign out_p     = st_q.res;
        end else begin : g_shared
            typedef struct packed {
                logic [OPW-1:0]  a;
                logic [OPW-1:0]  b;
                logic [OPW-1:0]  a2;    // operands one cycle late for the top group
                logic [OPW-1:0]  b2;
                logic [LAT-1:0]  vs;
                logic [RESW-1:0] hold;  // first half-product P0
                logic [RESW-1:0] r0;
                logic [RESW-1:0] p2d;
                logic [RESW-1:0] res;
            } sst_t;
            sst_t st_d, st_q;
            logic [TPA-1:0] ga;

            assign in_ready = ~st_q.vs[0];
            assign acc      = in_valid & in_ready;
            // second cycle after the take issues the upper low slice
            assign ga       = st_q.vs[1] ? a_low(st_q.a, 1) : a_low(st_q.a, 0);
            assign p1w      = '0;

            tmul_tile_group #(.NT(NTB), .AW(TPA), .BW(TPB), .SH(BSL), .OW(RESW)) u_grp01 (
                .clk(clk), .rst_n(rst_n), .a(ga), .b(b_narrow(st_q.b)), .p(p01));
            tmul_tile_group #(.NT(NTC), .AW(TPB), .BW(TPA), .SH(ASL), .OW(RESW)) u_grp2 (
                .clk(clk), .rst_n(rst_n), .a(a_top(st_q.a2)), .b(b_wide(st_q.b2)), .p(p2));

            always_comb begin
                st_d      = st_q;
                st_d.a    = acc ? in_a : st_q.a;
                st_d.b    = acc ? in_b : st_q.b;
                st_d.a2   = st_q.a;
                st_d.b2   = st_q.b;
                st_d.vs   = {st_q.vs[LAT-2:0], acc};
                st_d.hold = st_q.vs[3] ? p01 : st_q.hold;
                st_d.r0   = $signed(st_q.hold) + (p01 <<< ASL);
                st_d.p2d  = p2;
                st_d.res  = $signed(st_q.r0) + ($signed(st_q.p2d) <<< (2 * ASL));
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign out_valid = st_q.vs[LAT-1];
            assign out_p     = st_q.res;

            AST_TAKE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && in_ready) |=> !in_ready); // R4
            AST_READY_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
                !in_ready |=> in_ready); // R4
            AST_OUT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |=> !out_valid); // R4
        end
    endgenerate

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid && in_ready, 7)); // R2
    AST_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_p) ==
            (RESW'($signed($past(in_a, 7))) * RESW'($signed($past(in_b, 7)))))); // R1
endmodule

// File: tb/tmul65_tb.sv
module tmul65_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         v = 1'b0;
    logic [64:0]  a = '0, b = '0;
    logic         rdy_p, ov_p, rdy_s, ov_s;
    logic [129:0] op_p, op_s;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 1'b0, burst = 1'b0, idle_chk = 1'b0, prev_acc_s = 1'b0;
    logic [129:0] qp[$], qs[$];
    int tp[$], ts[$];

    always #4 clk = ~clk;

    tmul65 #(.SHARED(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(v), .in_ready(rdy_p),
        .in_a(a), .in_b(b), .out_valid(ov_p), .out_p(op_p));
    tmul65 #(.SHARED(1'b1)) dut_sh_i (
        .clk(clk), .rst_n(rst_n), .in_valid(v), .in_ready(rdy_s),
        .in_a(a), .in_b(b), .out_valid(ov_s), .out_p(op_s));

    function automatic logic [129:0] ref_mul(input logic [64:0] x, input logic [64:0] y);
        logic signed [129:0] sx, sy;
        sx = $signed(x);
        sy = $signed(y);
        return sx * sy;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [129:0] act, input logic [129:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_acc_s) chk(!rdy_s, "R4 ready low after take", 130'(rdy_s), 130'(0));
            prev_acc_s = v && rdy_s;
            if (burst) chk(rdy_p, "R3 pipelined always ready", 130'(rdy_p), 130'(1));
            if (idle_chk) chk(!ov_p && !ov_s, "R7 no output when idle", 130'({ov_p, ov_s}), 130'(0));
            if (ov_p) begin
                if (qp.size() == 0) chk(1'b0, "R7 pipelined spurious result", op_p, 130'(0));
                else begin
                    logic [129:0] e;
                    int t;
                    e = qp.pop_front();
                    t = tp.pop_front();
                    chk(op_p == e, "R1 R3 R5 pipelined product", op_p, e);
                    chk(cyc - t == 7, "R2 pipelined latency", 130'(cyc - t), 130'(7));
                end
            end
            if (ov_s) begin
                if (qs.size() == 0) chk(1'b0, "R7 shared spurious result", op_s, 130'(0));
                else begin
                    logic [129:0] e;
                    int t;
                    e = qs.pop_front();
                    t = ts.pop_front();
                    chk(op_s == e, "R1 R4 R5 shared product", op_s, e);
                    chk(cyc - t == 7, "R2 shared latency", 130'(cyc - t), 130'(7));
                end
            end
            if (v && rdy_p) begin qp.push_back(ref_mul(a, b)); tp.push_back(cyc); end
            if (v && rdy_s) begin qs.push_back(ref_mul(a, b)); ts.push_back(cyc); end
        end
    end

    // hold a pair until the shared variant takes it
    task automatic send(input logic [64:0] x, input logic [64:0] y);
        v = 1'b1; a = x; b = y;
        do @(negedge clk); while (!rdy_s);
        @(posedge clk); #1;
    endtask

    function automatic logic [64:0] rnd65();
        return 65'({$urandom(), $urandom(), $urandom()});
    endfunction

    logic [64:0] corner [10];

    initial begin
        void'($urandom(32'd20240611));
        corner[0] = 65'd0;
        corner[1] = 65'd1;
        corner[2] = {65{1'b1}};                         // -1
        corner[3] = {1'b0, {64{1'b1}}};                 // 2^64-1
        corner[4] = {1'b1, {63{1'b0}}, 1'b1};           // -(2^64-1)
        corner[5] = {1'b1, {64{1'b0}}};                 // -2^64
        corner[6] = 65'h0_0000_0000_00FF_FFFF;          // A slice edge at bit 24
        corner[7] = 65'h0_0008_0000_0001_FFFF;          // bits 51 and 0..16
        corner[8] = 65'h1_FFFF_0000_0002_0000;          // negative, bits 48.. and 17
        corner[9] = 65'h0_0001_0004_0000_0000;          // bits 48 and 34

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!ov_p && !ov_s, "R6 out_valid low after reset", 130'({ov_p, ov_s}), 130'(0));
        chk(rdy_p && rdy_s, "R6 in_ready high after reset", 130'({rdy_p, rdy_s}), 130'(3));
        @(posedge clk); #1;

        // R5: every pair of boundary operands
        for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j++)
                send(corner[i], corner[j]);

        // R7: idle stretch
        v = 1'b0;
        repeat (10) @(posedge clk);
        #1 idle_chk = 1'b1;
        repeat (8) @(posedge clk);
        #1 idle_chk = 1'b0;

        // R1: random pairs with idle gaps
        for (int n = 0; n < 300; n++) begin
            logic [64:0] x, y;
            x = rnd65();
            y = rnd65();
            if (n % 7 == 3) x = 65'($signed(32'($urandom())));
            if (n % 11 == 5) y = {65{y[64]}} ^ 65'($urandom_range(0, 255));
            send(x, y);
            if ($urandom_range(0, 3) == 0) begin
                v = 1'b0;
                repeat ($urandom_range(1, 3)) @(posedge clk);
                #1;
            end
        end

        // R3/R4: continuous burst, new operands every cycle
        burst = 1'b1;
        for (int n = 0; n < 200; n++) begin
            v = 1'b1; a = rnd65(); b = rnd65();
            @(posedge clk); #1;
        end
        burst = 1'b0;
        v = 1'b0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(qp.size() == 0, "R3 every pipelined pair answered", 130'(qp.size()), 130'(0));
        chk(qs.size() == 0, "R4 every shared pair answered", 130'(qs.size()), 130'(0));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule